// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small 16-bit processor that runs a program held in one external memory. It drives a byte address, reads instructions and data over a read-data bus, and writes data over a separate write-data bus under a write-enable strobe. Every instruction is one 16-bit word. The memory is expected to answer a read in the same cycle as its address, with no wait state.

Each instruction walks through a fixed sequence of states: fetch, decode, execute, and, where needed, memory access and write-back. Branches, jumps and the system-call opcode finish in three cycles. ALU, immediate, shift and store instructions take four cycles. Loads take five. The core holds sixteen registers, and register 0 is fixed at zero. A jump-and-link saves its return address in register 15. The system-call opcode does nothing here.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0. In the first cycle after reset, the core drives address 0 with `mem_we` low.
- R2: In every fetch cycle, `mem_addr` equals the PC and the instruction word is taken from `mem_rdata`. The PC then advances by 2.
- R3: The opcode sits in bits [15:12]. Register-format opcodes are 0 add, 1 sub, 2 and, 3 or and 8 slt, with source A in [11:8], source B in [7:4] and destination in [3:0]. slt gives 1 when A < B as signed values and 0 otherwise.
- R4: Register 0 always reads as zero. Any write aimed at it is discarded.
- R5: Opcode 4 (addi) adds the sign-extended byte [7:0] to the register named in [11:8] and writes the sum back there. Opcode 5 (lui) writes byte [7:0] into bits [15:8] of that register and clears bits [7:0].
- R6: Opcode 6 (sll) and opcode 7 (sra, arithmetic) shift the register in [7:4] by the unsigned amount in [3:0]. The result goes to the register in [11:8].
- R7: Opcode B (lw) reads the word at byte address reg[7:4] + sign_extend([3:0]) and writes it to the register in [11:8], in the fifth cycle.
- R8: Opcode F (sw) writes the register in [11:8] to byte address reg[7:4] + sign_extend([3:0]). `mem_we` is high only in the fourth cycle of a store.
- R9: Opcode 9 (beq) compares the registers in [11:8] and [7:4]. When they are equal, the PC becomes (address of beq + 2) + 2 × sign_extend([3:0]). Otherwise the PC moves on to the next word.
- R10: Opcode C (j) and opcode D (jal) load the PC with its own bits [15:12] followed by [11:0]. jal also writes (address of jal + 2) into register 15.
- R11: Opcode E (jr) loads the PC from the register named in [11:8].
- R12: Opcode A (syscall) changes no register or memory. beq, j, jal, jr and syscall take 3 cycles, other non-load opcodes take 4 and lw takes 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Byte address for a fetch, load or store |
| mem_rdata | input | 16 | Word read at `mem_addr`, valid in the same cycle |
| mem_wdata | output | 16 | Store data |
| mem_wdata is qualified by mem_we | | | |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |

## Verification
Two writes coincide in the execute cycle of jal: the link value goes into register 15 while the PC is overwritten with the jump target. Both use the PC value from before that edge. The bench calls a routine with jal, stores register 15 from the caller after `jr` returns, and compares it with the jal address plus 2. The check also confirms that the callee's side effect happened, so the target was reached. A second case is a load whose destination is register 0. Here the write-back and the zero-register rule meet in the fifth cycle, and a store of register 0 afterwards must produce zero.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

   localparam int ISA_W = 16;
   localparam int OPC_W = 4;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR   = 4'h3,
      OP_ADDI = 4'h4, OP_LUI = 4'h5, OP_SLL = 4'h6, OP_SRA  = 4'h7,
      OP_SLT  = 4'h8, OP_BEQ = 4'h9, OP_SYS = 4'hA, OP_LW   = 4'hB,
      OP_J    = 4'hC, OP_JAL = 4'hD, OP_JR  = 4'hE, OP_SW   = 4'hF
   } opcode_e;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
   } state_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRA, ALU_PASSB
   } alu_op_e;

   typedef enum logic [1:0] { PCS_INC, PCS_BR, PCS_JMP, PCS_REG } pc_sel_e;
   typedef enum logic       { A_RS, A_RT } a_sel_e;
   typedef enum logic [1:0] { B_RT, B_SE4, B_SE8, B_HIGH } b_sel_e;
   typedef enum logic [1:0] { WA_RD, WA_RS, WA_LINK } wa_sel_e;
   typedef enum logic [1:0] { WD_ALU, WD_MDR, WD_PC } wd_sel_e;

   typedef struct packed {
      logic    ir_we;
      logic    src_we;
      logic    pc_we;
      pc_sel_e pc_sel;
      a_sel_e  a_sel;
      b_sel_e  b_sel;
      alu_op_e alu_op;
      logic    alu_we;
      logic    addr_alu;
      logic    mem_we;
      logic    mdr_we;
      logic    rf_we;
      wa_sel_e wa_sel;
      wd_sel_e wd_sel;
   } ctrl_t;

   function automatic logic is_short(opcode_e op);
      return (op == OP_BEQ) || (op == OP_J) || (op == OP_JAL) ||
             (op == OP_JR)  || (op == OP_SYS);
   endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int DATA_W   = 16,
   parameter int AW       = 4,
   parameter bit ZERO_REG = 1'b1,
   localparam int N       = 1 << AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);

   logic [DATA_W-1:0] q [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      if (i == 0 && ZERO_REG) begin : g_zero
         assign q[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (rst)
               q[i] <= '0;
            else if (we && waddr == AW'(i))
               q[i] <= wdata;
         end
      end
   end

   assign rdata_a = q[raddr_a];
   assign rdata_b = q[raddr_b];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] shl [SH_W+1];
   logic [DATA_W-1:0] shr [SH_W+1];

   assign shl[0] = a;
   assign shr[0] = a;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int D = 1 << s;
      assign shl[s+1] = b[s] ? {shl[s][DATA_W-1-D:0], {D{1'b0}}} : shl[s];
      assign shr[s+1] = b[s] ? {{D{shr[s][DATA_W-1]}}, shr[s][DATA_W-1:D]} : shr[s];
   end

   logic lt;
   assign lt = $signed(a) < $signed(b);

   always_comb begin
      unique case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_SLT:   y = {{(DATA_W-1){1'b0}}, lt};
         ALU_SLL:   y = shl[SH_W];
         ALU_SRA:   y = shr[SH_W];
         default:   y = b;
      endcase
   end

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
   import mc16_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  opcode_e opcode,
   input  logic    eq,
   output state_e  state_q,
   output ctrl_t   cs
);

   state_e state_d;

   always_comb begin
      unique case (state_q)
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: state_d = ST_EXEC;
         ST_EXEC:   state_d = is_short(opcode) ? ST_FETCH : ST_MEM;
         ST_MEM:    state_d = (opcode == OP_LW) ? ST_WB : ST_FETCH;
         default:   state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      cs = '0;
      unique case (state_q)
         ST_FETCH: begin
            cs.ir_we  = 1'b1;
            cs.pc_we  = 1'b1;
            cs.pc_sel = PCS_INC;
         end
         ST_DECODE: cs.src_we = 1'b1;
         ST_EXEC: begin
            cs.alu_we = 1'b1;
            unique case (opcode)
               OP_ADD:  begin cs.a_sel = A_RS; cs.b_sel = B_RT;   cs.alu_op = ALU_ADD;   end
               OP_SUB:  begin cs.a_sel = A_RS; cs.b_sel = B_RT;   cs.alu_op = ALU_SUB;   end
               OP_AND:  begin cs.a_sel = A_RS; cs.b_sel = B_RT;   cs.alu_op = ALU_AND;   end
               OP_OR:   begin cs.a_sel = A_RS; cs.b_sel = B_RT;   cs.alu_op = ALU_OR;    end
               OP_SLT:  begin cs.a_sel = A_RS; cs.b_sel = B_RT;   cs.alu_op = ALU_SLT;   end
               OP_ADDI: begin cs.a_sel = A_RS; cs.b_sel = B_SE8;  cs.alu_op = ALU_ADD;   end
               OP_LUI:  begin cs.a_sel = A_RS; cs.b_sel = B_HIGH; cs.alu_op = ALU_PASSB; end
               OP_SLL:  begin cs.a_sel = A_RT; cs.b_sel = B_SE4;  cs.alu_op = ALU_SLL;   end
               OP_SRA:  begin cs.a_sel = A_RT; cs.b_sel = B_SE4;  cs.alu_op = ALU_SRA;   end
               OP_LW, OP_SW: begin
                  cs.a_sel = A_RT; cs.b_sel = B_SE4; cs.alu_op = ALU_ADD;
               end
               OP_BEQ: begin
                  cs.pc_we  = eq;
                  cs.pc_sel = PCS_BR;
               end
               OP_J: begin
                  cs.pc_we  = 1'b1;
                  cs.pc_sel = PCS_JMP;
               end
               OP_JAL: begin
                  cs.pc_we  = 1'b1;
                  cs.pc_sel = PCS_JMP;
                  cs.rf_we  = 1'b1;
                  cs.wa_sel = WA_LINK;
                  cs.wd_sel = WD_PC;
               end
               OP_JR: begin
                  cs.pc_we  = 1'b1;
                  cs.pc_sel = PCS_REG;
               end
               default: cs.alu_we = 1'b0;
            endcase
         end
         ST_MEM: begin
            unique case (opcode)
               OP_LW: begin
                  cs.addr_alu = 1'b1;
                  cs.mdr_we   = 1'b1;
               end
               OP_SW: begin
                  cs.addr_alu = 1'b1;
                  cs.mem_we   = 1'b1;
               end
               OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT: begin
                  cs.rf_we  = 1'b1;
                  cs.wa_sel = WA_RD;
                  cs.wd_sel = WD_ALU;
               end
               OP_ADDI, OP_LUI, OP_SLL, OP_SRA: begin
                  cs.rf_we  = 1'b1;
                  cs.wa_sel = WA_RS;
                  cs.wd_sel = WD_ALU;
               end
               default: cs.rf_we = 1'b0;
            endcase
         end
         default: begin
            cs.rf_we  = 1'b1;
            cs.wa_sel = WA_RS;
            cs.wd_sel = WD_MDR;
         end
      endcase
   end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              REG_AW   = 4,
   parameter logic [DATA_W-1:0] RESET_PC = '0,
   parameter int              LINK_REG = 15,
   parameter int              BR_SHIFT = 1,
   parameter bit              ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we
);

   localparam int J_W    = 12;
   localparam int IMM8_W = 8;
   localparam int IMM4_W = 4;

   if (DATA_W != ISA_W) begin : g_bad_width
      $error("mc16_core: DATA_W must equal the 16-bit instruction width");
   end
   if (REG_AW != 4) begin : g_bad_regs
      $error("mc16_core: register fields are 4 bits wide");
   end
   if (LINK_REG < 1 || LINK_REG >= (1 << REG_AW)) begin : g_bad_link
      $error("mc16_core: LINK_REG out of range");
   end

   logic [DATA_W-1:0] pc_q, ir_q, rs_q, rt_q, alu_q, mdr_q;
   state_e            state_q;
   ctrl_t             cs;
   opcode_e           opcode;
   logic              eq;

   assign opcode = opcode_e'(ir_q[15:12]);
   assign eq     = (rs_q == rt_q);

   mc16_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .opcode  (opcode),
      .eq      (eq),
      .state_q (state_q),
      .cs      (cs)
   );

   // Immediate forms
   logic [DATA_W-1:0] se4, se8, high8, br_off;
   assign se4    = {{(DATA_W-IMM4_W){ir_q[IMM4_W-1]}}, ir_q[IMM4_W-1:0]};
   assign se8    = {{(DATA_W-IMM8_W){ir_q[IMM8_W-1]}}, ir_q[IMM8_W-1:0]};
   assign high8  = {ir_q[IMM8_W-1:0], {(DATA_W-IMM8_W){1'b0}}};
   assign br_off = se4 << BR_SHIFT;

   // Register file
   logic [REG_AW-1:0] rf_waddr;
   logic [DATA_W-1:0] rf_wdata, rf_a, rf_b;

   always_comb begin
      unique case (cs.wa_sel)
         WA_RD:   rf_waddr = ir_q[REG_AW-1:0];
         WA_RS:   rf_waddr = ir_q[11:8];
         default: rf_waddr = REG_AW'(LINK_REG);
      endcase
      unique case (cs.wd_sel)
         WD_ALU:  rf_wdata = alu_q;
         WD_MDR:  rf_wdata = mdr_q;
         default: rf_wdata = pc_q;
      endcase
   end

   mc16_regfile #(
      .DATA_W   (DATA_W),
      .AW       (REG_AW),
      .ZERO_REG (ZERO_REG)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (cs.rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (ir_q[11:8]),
      .raddr_b (ir_q[7:4]),
      .rdata_a (rf_a),
      .rdata_b (rf_b)
   );

   // ALU operand selection
   logic [DATA_W-1:0] alu_a, alu_b, alu_y;

   always_comb begin
      alu_a = (cs.a_sel == A_RT) ? rt_q : rs_q;
      unique case (cs.b_sel)
         B_RT:    alu_b = rt_q;
         B_SE4:   alu_b = se4;
         B_SE8:   alu_b = se8;
         default: alu_b = high8;
      endcase
   end

   mc16_alu #(.DATA_W(DATA_W)) u_alu (
      .op (cs.alu_op),
      .a  (alu_a),
      .b  (alu_b),
      .y  (alu_y)
   );

   // Program counter
   logic [DATA_W-1:0] pc_d;

   always_comb begin
      unique case (cs.pc_sel)
         PCS_INC: pc_d = pc_q + DATA_W'(2);
         PCS_BR:  pc_d = pc_q + br_off;
         PCS_JMP: pc_d = {pc_q[DATA_W-1:J_W], ir_q[J_W-1:0]};
         default: pc_d = rs_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         rs_q  <= '0;
         rt_q  <= '0;
         alu_q <= '0;
         mdr_q <= '0;
      end else begin
         if (cs.pc_we)  pc_q  <= pc_d;
         if (cs.ir_we)  ir_q  <= mem_rdata;
         if (cs.src_we) begin
            rs_q <= rf_a;
            rt_q <= rf_b;
         end
         if (cs.alu_we) alu_q <= alu_y;
         if (cs.mdr_we) mdr_q <= mem_rdata;
      end
   end

   assign mem_addr  = cs.addr_alu ? alu_q : pc_q;
   assign mem_wdata = rs_q;
   assign mem_we    = cs.mem_we;

endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
   import mc16_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] RESET_PC = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] pc_q,
   input state_e            state,
   input logic [3:0]        opcode
);

   // R1: first cycle after reset fetches from the reset address
   a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_addr == RESET_PC && state == ST_FETCH && !mem_we));

   // R2: fetch address is the PC
   a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |-> (mem_addr == pc_q));

   // R2: PC moves on by one word after each fetch
   a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (pc_q == $past(pc_q) + DATA_W'(2)));

   // R8: write strobe only in the memory cycle of a store
   a_r8_store_window: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (state == ST_MEM && opcode == OP_SW));

   // R7: the fifth cycle belongs to loads only
   a_r7_wb_load_only: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WB) |-> (opcode == OP_LW && $past(state) == ST_MEM));

   // R12: control-flow and syscall end after execute
   a_r12_short_ops: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && (opcode == OP_BEQ || opcode == OP_J ||
       opcode == OP_JAL || opcode == OP_JR || opcode == OP_SYS))
      |=> (state == ST_FETCH));

   // R12: decode always follows a fetch
   a_r12_decode_order: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

endmodule

bind mc16_core mc16_core_chk #(
   .DATA_W   (DATA_W),
   .RESET_PC (RESET_PC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .pc_q     (pc_q),
   .state    (state_q),
   .opcode   (ir_q[15:12])
);

// File: tb/mc16_core_tb_top.sv
`timescale 1ns/1ps
module mc16_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] mem_addr, mem_rdata, mem_wdata;
   logic        mem_we;

   always #2 clk = ~clk;

   mc16_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we)
   );

   logic [15:0] mem [256];
   assign mem_rdata = mem[mem_addr[8:1]];
   always @(posedge clk) if (mem_we) mem[mem_addr[8:1]] = mem_wdata;

   int errs   = 0;
   int checks = 0;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic run(input int n);
      rst = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] hi_part(input logic [15:0] v);
      return v[15:8] + {7'b0, v[7]};
   endfunction

   task automatic measure(output int first);
      first = -1;
      rst = 1'b0;
      for (int c = 0; c < 60; c++) begin
         #1;
         if (mem_we && first < 0) first = c;
         @(negedge clk);
      end
   endtask

   logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                             16'hFFFF, 16'h1234, 16'h00FF, 16'hFF80};

   initial begin
      int first;
      // R1: reset state
      hold();
      chk("R1 reset addr", mem_addr, 16'h0000);
      chk("R1 reset we", {15'b0, mem_we}, 16'h0000);

      // R3 R5 R6 R8: operand sweep
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            logic [15:0] a, b;
            logic [3:0]  k;
            a = vals[i];
            b = vals[j];
            k = 4'((i * 3 + j) % 16);
            hold();
            mem[0]  = {8'h51, hi_part(a)};
            mem[1]  = {8'h41, a[7:0]};
            mem[2]  = {8'h52, hi_part(b)};
            mem[3]  = {8'h42, b[7:0]};
            mem[4]  = 16'h5401;
            mem[5]  = 16'h0125;
            mem[6]  = 16'h1126;
            mem[7]  = 16'h2127;
            mem[8]  = 16'h3128;
            mem[9]  = 16'h8129;
            mem[10] = {12'h6A1, k};
            mem[11] = {12'h7B1, k};
            mem[12] = 16'hF540;
            mem[13] = 16'hF642;
            mem[14] = 16'hF744;
            mem[15] = 16'hF846;
            mem[16] = 16'hF94E;
            mem[17] = 16'hFA4C;
            mem[18] = 16'hFB4A;
            mem[19] = 16'h900F;
            run(110);
            chk("R3 add (R5 built operands)", mem[128], a + b);
            chk("R3 sub", mem[129], a - b);
            chk("R3 and", mem[130], a & b);
            chk("R3 or", mem[131], a | b);
            chk("R3 slt", mem[127], {15'b0, $signed(a) < $signed(b)});
            chk("R6 sll", mem[126], a << k);
            chk("R6 sra", mem[125], 16'($signed(a) >>> k));
         end
      end

      // R4 R5 R7 R8: zero register, loads, lui
      hold();
      mem[129] = 16'hBEEF;
      mem[127] = 16'h8001;
      mem[126] = 16'h1111;
      mem[125] = 16'hFFFF;
      mem[124] = 16'hFFFF;
      mem[0]  = 16'h5401;
      mem[1]  = 16'h4055;
      mem[2]  = 16'h5012;
      mem[3]  = 16'h0440;
      mem[4]  = 16'hF040;
      mem[5]  = 16'hB542;
      mem[6]  = 16'h4501;
      mem[7]  = 16'hF544;
      mem[8]  = 16'hB64E;
      mem[9]  = 16'hF646;
      mem[10] = 16'hB042;
      mem[11] = 16'hF04C;
      mem[12] = 16'h57A5;
      mem[13] = 16'hF74A;
      mem[14] = 16'h47FF;
      mem[15] = 16'hF748;
      mem[16] = 16'h900F;
      run(110);
      chk("R4 r0 after addi/lui/add", mem[128], 16'h0000);
      chk("R7 lw positive offset", mem[130], 16'hBEF0);
      chk("R7 lw negative offset", mem[131], 16'h8001);
      chk("R4 lw into r0 ignored", mem[126], 16'h0000);
      chk("R5 lui clears low byte", mem[125], 16'hA500);
      chk("R5 addi negative", mem[124], 16'hA4FF);

      // R9: taken, not taken, backward loop
      hold();
      mem[0]  = 16'h5401;
      mem[1]  = 16'h4103;
      mem[2]  = 16'h4203;
      mem[3]  = 16'h9122;
      mem[4]  = 16'h4501;
      mem[5]  = 16'h4502;
      mem[6]  = 16'h4504;
      mem[7]  = 16'h9101;
      mem[8]  = 16'h4508;
      mem[9]  = 16'h4601;
      mem[10] = 16'h9611;
      mem[11] = 16'h900D;
      mem[12] = 16'hF540;
      mem[13] = 16'hF642;
      mem[14] = 16'h900F;
      run(130);
      chk("R9 forward taken and not taken", mem[128], 16'h000C);
      chk("R9 backward loop count", mem[129], 16'h0003);

      // R10 R11 R12: jal, jr, j, syscall
      hold();
      mem[0]  = 16'h5401;
      mem[1]  = 16'hD020;
      mem[2]  = 16'hF540;
      mem[3]  = 16'hFF42;
      mem[4]  = 16'hC030;
      mem[5]  = 16'h457F;
      mem[16] = 16'h4521;
      mem[17] = 16'hEF00;
      mem[24] = 16'hA000;
      mem[25] = 16'h4609;
      mem[26] = 16'hF644;
      mem[27] = 16'h900F;
      run(110);
      chk("R10 jal target reached", mem[128], 16'h0021);
      chk("R10 jal link value (R11 return)", mem[129], 16'h0004);
      chk("R10 j target and R12 syscall no-op", mem[130], 16'h0009);

      // R12 R7: cycle counts
      hold();
      mem[0] = 16'h5401;
      mem[1] = 16'hB540;
      mem[2] = 16'h9401;
      mem[3] = 16'hA000;
      mem[4] = 16'hF042;
      mem[5] = 16'h900F;
      measure(first);
      chk("R12 cycles lui+lw+beq+syscall to store", 16'(first), 16'd18);

      hold();
      mem[0] = 16'h5401;
      mem[1] = 16'h4101;
      mem[2] = 16'hC006;
      mem[3] = 16'hF140;
      mem[4] = 16'h900F;
      measure(first);
      chk("R12 cycles lui+addi+j to store", 16'(first), 16'd14);
      chk("R8 store of rs after jump", mem[128], 16'h0001);

      // R1: reset after activity returns fetch to 0
      hold();
      chk("R1 addr under reset after run", mem_addr, 16'h0000);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(4ns * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule